// File: doc/BRIEF.md
# Hardware Thread Context Fork Allocator

The allocator serves a fork request from a running hardware thread context. It walks a pool of thread contexts to find a free one that is bound to the same virtual processing element (VPE) as the requester. A context counts as free when dynamic allocation is permitted for it, it is not halted, and it is not already activated. The allocator claims the first such context it finds. For that context it emits one write strobe that loads the restart program counter, one strobe that writes a destination register, and one strobe that updates the context's status fields. If the search finds no free context, the allocator reports a thread exception code and a fault pulse.

The scan is a four-state machine. IDLE waits for a request. On the transition IDLE→SCAN the request is taken and the request fields are latched. SCAN examines one context per clock. The transition SCAN→CLAIM is taken when the context under examination is eligible. SCAN→FAIL is taken when the last context in range is examined and is not eligible. SCAN→SCAN moves on to the next index. CLAIM and FAIL each last exactly one cycle and always return to IDLE. The per-context status arrays must stay stable while a search is running. Instruction decode and pipeline control sit outside this block.

Top module: `fork_alloc`

## Requirements
- R1: The number of contexts searched is `ctx_limit + 1`. If that count is larger than `NUM_CTX`, the search stops at index `NUM_CTX-1`. A context above the limit is never claimed, even if it is eligible.
- R2: Contexts are examined in ascending index order starting at 0. The lowest-indexed eligible context within range is the one claimed.
- R3: Context t is eligible only when all four of these hold:
  - its 2-bit VPE field `ctx_vpe[2t+1:2t]` equals `req_vpe`;
  - `ctx_dyn[t]` is 1;
  - `ctx_halt[t]` is 0;
  - `ctx_active[t]` is 0.
- R4: On a claim, during the single CLAIM cycle:
  - `restart_we` and `reg_we` pulse;
  - `tgt_idx` carries the claimed index;
  - `restart_pc` carries the latched `fork_pc`;
  - `reg_idx` and `reg_data` carry the latched `fork_rd` and `fork_val`.
- R5: On a claim, `stat_we` pulses with these status values: `stat_run` = 0 (running), `stat_delay` = 0, `stat_dirty` = 1 and `stat_active` = 1.
- R6: On a claim, `stat_mode` and `stat_asid` carry the requester's `req_mode` and `req_asid`, as latched when the request was accepted.
- R7: When no context is claimed, the FAIL cycle raises `fault` with `exc_code` = 1. No write strobe fires in that cycle.
- R8: Timing counts from the clock edge that accepts a request. If context k is claimed, `done` is high in the cycle after edge k+1. If the search fails over n contexts, `done` is high in the cycle after edge n. `busy` is high from acceptance through the `done` cycle.
- R9: A request that arrives while `busy` is high is ignored. It changes neither the result nor the latched operands of the search in progress.
- R10: Every strobe, and `done`, is a single-cycle pulse. Each `done` comes with exactly one of `claim_ok` and `fault`.
- R11: During and after reset, with no request, every output is 0. All data fields are 0 whenever their strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fork_req | input | 1 | Fork request, sampled in IDLE |
| fork_pc | input | PC_W | Restart PC for the new context |
| fork_rd | input | REG_W | Destination register index |
| fork_val | input | DATA_W | Value for the destination register |
| req_vpe | input | VPE_W | Requester's VPE binding |
| req_mode | input | MODE_W | Requester's current privilege mode |
| req_asid | input | ASID_W | Requester's address-space ID |
| ctx_limit | input | IDX_W | Highest context index to search |
| ctx_vpe | input | NUM_CTX*VPE_W | Per-context VPE binding, packed |
| ctx_dyn | input | NUM_CTX | Per-context dynamic-allocation permitted |
| ctx_halt | input | NUM_CTX | Per-context halted |
| ctx_active | input | NUM_CTX | Per-context activated |
| busy | output | 1 | Search in progress |
| done | output | 1 | Search complete pulse |
| claim_ok | output | 1 | A context was claimed |
| fault | output | 1 | Thread fault pulse |
| exc_code | output | 3 | Exception code, 1 on a failed fork |
| tgt_idx | output | IDX_W | Claimed context index |
| restart_we | output | 1 | Restart-PC write strobe |
| restart_pc | output | PC_W | Restart-PC value |
| reg_we | output | 1 | Register write strobe |
| reg_idx | output | REG_W | Register index written |
| reg_data | output | DATA_W | Register data written |
| stat_we | output | 1 | Status write strobe |
| stat_run | output | 2 | Run-state written |
| stat_delay | output | 1 | Delay-slot flag written |
| stat_dirty | output | 1 | Dirty flag written |
| stat_active | output | 1 | Activated bit written |
| stat_mode | output | MODE_W | Mode written |
| stat_asid | output | ASID_W | ASID written |

## Verification
The bench places the only eligible context exactly at the search limit and then one past it. A design with an off-by-one limit would claim a context it must not, or would miss the one it should claim. Each of the four eligibility conditions is made to fail on its own in a lower context that sits ahead of an eligible one. A design that ignores any one of those bits would claim the wrong index, and the cycle-exact model would see `done` arrive early. A request is held high with fresh operands during a search and again across the CLAIM cycle. A design that restarts the scan, re-latches operands, or accepts a request straight out of CLAIM would show a shifted `done` or the wrong PC or data.

// File: rtl/fork_alloc_pkg.sv
package fork_alloc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_CLAIM = 2'd2,
        ST_FAIL  = 2'd3
    } fork_state_e;

    localparam int EXC_W = 3;
    localparam logic [EXC_W-1:0] EXC_NO_FREE_CTX = 3'd1;
    localparam int RUN_W = 2;
    localparam logic [RUN_W-1:0] RUN_RUNNING = 2'd0;
endpackage

// File: rtl/fork_elig.sv
module fork_elig #(
    parameter int NUM_CTX = 8,
    parameter int VPE_W   = 2
) (
    input  logic [NUM_CTX*VPE_W-1:0] ctx_vpe,
    input  logic [VPE_W-1:0]         req_vpe,
    input  logic [NUM_CTX-1:0]       ctx_dyn,
    input  logic [NUM_CTX-1:0]       ctx_halt,
    input  logic [NUM_CTX-1:0]       ctx_active,
    output logic [NUM_CTX-1:0]       elig
);
    // One eligibility term per context: same VPE, allocatable, running, free.
    for (genvar t = 0; t < NUM_CTX; t++) begin : g_ctx
        assign elig[t] = (ctx_vpe[t*VPE_W +: VPE_W] == req_vpe)
                       && ctx_dyn[t] && !ctx_halt[t] && !ctx_active[t];
    end
endmodule

// File: rtl/fork_scan.sv
module fork_scan
    import fork_alloc_pkg::*;
#(
    parameter int NUM_CTX = 8,
    parameter int IDX_W   = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [NUM_CTX-1:0] elig,
    input  logic [IDX_W-1:0]   ctx_limit,
    output fork_state_e        state,
    output logic [IDX_W-1:0]   idx
);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_CTX - 1);

    fork_state_e      state_nx;
    logic [IDX_W-1:0] idx_nx;
    logic             at_last;

    assign at_last = (idx == ctx_limit) || (idx == TOP_IDX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            state <= state_nx;
            idx   <= idx_nx;
        end
    end

    always_comb begin
        state_nx = state;
        idx_nx   = idx;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nx = ST_SCAN;
                    idx_nx   = '0;
                end
            end
            ST_SCAN: begin
                if (elig[idx]) begin
                    state_nx = ST_CLAIM;  // idx keeps the claimed index
                end else if (at_last) begin
                    state_nx = ST_FAIL;
                end else begin
                    idx_nx = idx + 1'b1;
                end
            end
            ST_CLAIM: state_nx = ST_IDLE;
            ST_FAIL:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/fork_alloc.sv
module fork_alloc
    import fork_alloc_pkg::*;
#(
    parameter int NUM_CTX = 8,
    parameter int PC_W    = 32,
    parameter int DATA_W  = 32,
    parameter int REG_W   = 5,
    parameter int VPE_W   = 2,
    parameter int MODE_W  = 2,
    parameter int ASID_W  = 8,
    parameter int IDX_W   = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fork_req,
    input  logic [PC_W-1:0]          fork_pc,
    input  logic [REG_W-1:0]         fork_rd,
    input  logic [DATA_W-1:0]        fork_val,
    input  logic [VPE_W-1:0]         req_vpe,
    input  logic [MODE_W-1:0]        req_mode,
    input  logic [ASID_W-1:0]        req_asid,
    input  logic [IDX_W-1:0]         ctx_limit,
    input  logic [NUM_CTX*VPE_W-1:0] ctx_vpe,
    input  logic [NUM_CTX-1:0]       ctx_dyn,
    input  logic [NUM_CTX-1:0]       ctx_halt,
    input  logic [NUM_CTX-1:0]       ctx_active,
    output logic                     busy,
    output logic                     done,
    output logic                     claim_ok,
    output logic                     fault,
    output logic [EXC_W-1:0]         exc_code,
    output logic [IDX_W-1:0]         tgt_idx,
    output logic                     restart_we,
    output logic [PC_W-1:0]          restart_pc,
    output logic                     reg_we,
    output logic [REG_W-1:0]         reg_idx,
    output logic [DATA_W-1:0]        reg_data,
    output logic                     stat_we,
    output logic [RUN_W-1:0]         stat_run,
    output logic                     stat_delay,
    output logic                     stat_dirty,
    output logic                     stat_active,
    output logic [MODE_W-1:0]        stat_mode,
    output logic [ASID_W-1:0]        stat_asid
);
    fork_state_e       state;
    logic [IDX_W-1:0]  idx;
    logic [NUM_CTX-1:0] elig;
    logic              start;
    logic [VPE_W-1:0]  vpe_q;
    logic [PC_W-1:0]   pc_q;
    logic [REG_W-1:0]  rd_q;
    logic [DATA_W-1:0] val_q;
    logic [MODE_W-1:0] mode_q;
    logic [ASID_W-1:0] asid_q;

    assign start = (state == ST_IDLE) && fork_req;

    // Operands are captured only on acceptance, so requests seen while busy leave them alone.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpe_q  <= '0;
            pc_q   <= '0;
            rd_q   <= '0;
            val_q  <= '0;
            mode_q <= '0;
            asid_q <= '0;
        end else if (start) begin
            vpe_q  <= req_vpe;
            pc_q   <= fork_pc;
            rd_q   <= fork_rd;
            val_q  <= fork_val;
            mode_q <= req_mode;
            asid_q <= req_asid;
        end
    end

    fork_elig #(.NUM_CTX(NUM_CTX), .VPE_W(VPE_W)) u_elig (
        .ctx_vpe    (ctx_vpe),
        .req_vpe    (vpe_q),
        .ctx_dyn    (ctx_dyn),
        .ctx_halt   (ctx_halt),
        .ctx_active (ctx_active),
        .elig       (elig)
    );

    fork_scan #(.NUM_CTX(NUM_CTX), .IDX_W(IDX_W)) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .elig      (elig),
        .ctx_limit (ctx_limit),
        .state     (state),
        .idx       (idx)
    );

    always_comb begin
        busy        = 1'b0;
        done        = 1'b0;
        claim_ok    = 1'b0;
        fault       = 1'b0;
        exc_code    = '0;
        tgt_idx     = '0;
        restart_we  = 1'b0;
        restart_pc  = '0;
        reg_we      = 1'b0;
        reg_idx     = '0;
        reg_data    = '0;
        stat_we     = 1'b0;
        stat_run    = '0;
        stat_delay  = 1'b0;
        stat_dirty  = 1'b0;
        stat_active = 1'b0;
        stat_mode   = '0;
        stat_asid   = '0;
        unique case (state)
            ST_IDLE: ;
            ST_SCAN: busy = 1'b1;
            ST_CLAIM: begin
                busy        = 1'b1;
                done        = 1'b1;
                claim_ok    = 1'b1;
                tgt_idx     = idx;
                restart_we  = 1'b1;
                restart_pc  = pc_q;
                reg_we      = 1'b1;
                reg_idx     = rd_q;
                reg_data    = val_q;
                stat_we     = 1'b1;
                stat_run    = RUN_RUNNING;
                stat_delay  = 1'b0;
                stat_dirty  = 1'b1;
                stat_active = 1'b1;
                stat_mode   = mode_q;
                stat_asid   = asid_q;
            end
            ST_FAIL: begin
                busy     = 1'b1;
                done     = 1'b1;
                fault    = 1'b1;
                exc_code = EXC_NO_FREE_CTX;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fork_alloc_chk.sv
module fork_alloc_chk #(
    parameter int RUN_W = 2,
    parameter int EXC_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             claim_ok,
    input logic             fault,
    input logic [EXC_W-1:0] exc_code,
    input logic             restart_we,
    input logic             reg_we,
    input logic             stat_we,
    input logic [RUN_W-1:0] stat_run,
    input logic             stat_delay,
    input logic             stat_dirty,
    input logic             stat_active
);
    a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (claim_ok != fault));

    a_r10_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    a_r4_strobes_together: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (restart_we && stat_we && done));

    a_r5_status_values: assert property (@(posedge clk) disable iff (!rst_n)
        stat_we |-> (stat_run == '0 && !stat_delay && stat_dirty && stat_active));

    a_r7_fault_code: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (exc_code == 3'd1 && !reg_we && !restart_we && !stat_we));

    a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));
endmodule

bind fork_alloc fork_alloc_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .claim_ok    (claim_ok),
    .fault       (fault),
    .exc_code    (exc_code),
    .restart_we  (restart_we),
    .reg_we      (reg_we),
    .stat_we     (stat_we),
    .stat_run    (stat_run),
    .stat_delay  (stat_delay),
    .stat_dirty  (stat_dirty),
    .stat_active (stat_active)
);

// File: tb/fork_alloc_bench.sv
`timescale 1ns/100ps
module fork_alloc_bench;
    localparam int N = 8;
    localparam int IW = 3;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic fork_req = 1'b0;
    logic [31:0] fork_pc = '0;
    logic [4:0] fork_rd = '0;
    logic [31:0] fork_val = '0;
    logic [1:0] req_vpe = '0;
    logic [1:0] req_mode = '0;
    logic [7:0] req_asid = '0;
    logic [IW-1:0] ctx_limit = '0;
    logic [2*N-1:0] ctx_vpe = '0;
    logic [N-1:0] ctx_dyn = '0, ctx_halt = '0, ctx_active = '0;

    logic busy, done, claim_ok, fault, restart_we, reg_we, stat_we;
    logic stat_delay, stat_dirty, stat_active;
    logic [2:0] exc_code;
    logic [IW-1:0] tgt_idx;
    logic [31:0] restart_pc, reg_data;
    logic [4:0] reg_idx;
    logic [1:0] stat_run, stat_mode;
    logic [7:0] stat_asid;

    fork_alloc u_fork_alloc (
        .clk(clk), .rst_n(rst_n), .fork_req(fork_req), .fork_pc(fork_pc),
        .fork_rd(fork_rd), .fork_val(fork_val), .req_vpe(req_vpe),
        .req_mode(req_mode), .req_asid(req_asid), .ctx_limit(ctx_limit),
        .ctx_vpe(ctx_vpe), .ctx_dyn(ctx_dyn), .ctx_halt(ctx_halt),
        .ctx_active(ctx_active), .busy(busy), .done(done), .claim_ok(claim_ok),
        .fault(fault), .exc_code(exc_code), .tgt_idx(tgt_idx),
        .restart_we(restart_we), .restart_pc(restart_pc), .reg_we(reg_we),
        .reg_idx(reg_idx), .reg_data(reg_data), .stat_we(stat_we),
        .stat_run(stat_run), .stat_delay(stat_delay), .stat_dirty(stat_dirty),
        .stat_active(stat_active), .stat_mode(stat_mode), .stat_asid(stat_asid)
    );

    int checks = 0;
    int errors = 0;
    string scen = "R11 reset";
    bit finished = 0;

    // Behavioural reference: cycles remaining until done, -1 when idle.
    int m_wait = -1;
    bit m_ok = 0;
    int m_tgt = 0;
    logic [31:0] m_pc, m_val;
    logic [4:0] m_rd;
    logic [1:0] m_mode;
    logic [7:0] m_asid;

    always @(posedge clk) begin
        if (!rst_n) m_wait = -1;
        else if (m_wait == 0) m_wait = -1;
        else if (m_wait > 0) m_wait = m_wait - 1;
        else if (fork_req) begin
            int lim;
            lim = int'(ctx_limit);
            if (lim > N - 1) lim = N - 1;
            m_ok = 0;
            m_tgt = 0;
            for (int t = 0; t <= lim; t++) begin
                if (!m_ok && ctx_vpe[t*2 +: 2] == req_vpe && ctx_dyn[t]
                    && !ctx_halt[t] && !ctx_active[t]) begin
                    m_ok = 1;
                    m_tgt = t;
                end
            end
            m_wait = m_ok ? m_tgt + 1 : lim + 1;
            m_pc = fork_pc; m_val = fork_val; m_rd = fork_rd;
            m_mode = req_mode; m_asid = req_asid;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (%s): actual %0h expected %0h at %0t", tag, scen, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            bit e_done, e_claim, e_fault;
            e_done  = (m_wait == 0);
            e_claim = e_done && m_ok;
            e_fault = e_done && !m_ok;
            chk("R8 busy", busy, m_wait >= 0);
            chk("R8 done", done, e_done);
            chk("R10 claim_ok", claim_ok, e_claim);
            chk("R7 fault", fault, e_fault);
            chk("R7 exc_code", exc_code, e_fault ? 1 : 0);
            chk("R4 tgt_idx", tgt_idx, e_claim ? m_tgt : 0);
            chk("R4 restart_we", restart_we, e_claim);
            chk("R4 restart_pc", restart_pc, e_claim ? m_pc : 0);
            chk("R4 reg_we", reg_we, e_claim);
            chk("R4 reg_idx", reg_idx, e_claim ? m_rd : 0);
            chk("R4 reg_data", reg_data, e_claim ? m_val : 0);
            chk("R5 stat_we", stat_we, e_claim);
            chk("R5 stat_run", stat_run, 0);
            chk("R5 stat_delay", stat_delay, 0);
            chk("R5 stat_dirty", stat_dirty, e_claim);
            chk("R5 stat_active", stat_active, e_claim);
            chk("R6 stat_mode", stat_mode, e_claim ? m_mode : 0);
            chk("R6 stat_asid", stat_asid, e_claim ? m_asid : 0);
        end
    end

    task automatic set_ctx(input int t, input logic [1:0] v, input bit dyn,
                           input bit halt, input bit act);
        ctx_vpe[t*2 +: 2] = v;
        ctx_dyn[t] = dyn;
        ctx_halt[t] = halt;
        ctx_active[t] = act;
    endtask

    task automatic clear_ctx();
        ctx_vpe = '0; ctx_dyn = '0; ctx_halt = '0; ctx_active = '0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_fork(input logic [31:0] pc, input logic [4:0] rd,
                           input logic [31:0] val, input logic [1:0] mode,
                           input logic [7:0] asid);
        @(negedge clk);
        fork_pc = pc; fork_rd = rd; fork_val = val;
        req_mode = mode; req_asid = asid;
        fork_req = 1'b1;
        @(negedge clk);
        fork_req = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3: context 0 eligible immediately
        scen = "R3 ctx0 free";
        req_vpe = 2'd1; ctx_limit = 3'd7;
        clear_ctx();
        set_ctx(0, 2'd1, 1, 0, 0);
        do_fork(32'h0000_1000, 5'd3, 32'hDEAD_BEEF, 2'd2, 8'h5A);

        // R2: first of several eligible wins
        scen = "R2 first of many";
        clear_ctx();
        set_ctx(1, 2'd1, 1, 0, 0);
        set_ctx(3, 2'd1, 1, 0, 0);
        set_ctx(5, 2'd1, 1, 0, 0);
        do_fork(32'h0000_2004, 5'd31, 32'h1234_5678, 2'd1, 8'hA3);

        // R3: each eligibility term failing alone ahead of a free context
        scen = "R3 each term";
        clear_ctx();
        set_ctx(0, 2'd2, 1, 0, 0);
        set_ctx(1, 2'd1, 0, 0, 0);
        set_ctx(2, 2'd1, 1, 1, 0);
        set_ctx(3, 2'd1, 1, 0, 1);
        set_ctx(4, 2'd1, 1, 0, 0);
        do_fork(32'hCAFE_0000, 5'd7, 32'h0BAD_F00D, 2'd0, 8'hFF);

        // R1 / R7: only eligible context lies one past the limit
        scen = "R1 R7 beyond limit";
        clear_ctx();
        set_ctx(5, 2'd1, 1, 0, 0);
        ctx_limit = 3'd4;
        do_fork(32'h0000_3000, 5'd1, 32'h1111_2222, 2'd3, 8'h01);

        // R1: limit exactly on the eligible context
        scen = "R1 at limit";
        ctx_limit = 3'd5;
        do_fork(32'h0000_3008, 5'd2, 32'h3333_4444, 2'd1, 8'h02);

        // R1 / R2: full pool, last context is the only one
        scen = "R1 last ctx";
        clear_ctx();
        set_ctx(7, 2'd1, 1, 0, 0);
        ctx_limit = 3'd7;
        do_fork(32'h0000_4000, 5'd9, 32'h5555_6666, 2'd2, 8'h77);

        // R7: nothing free in the full pool
        scen = "R7 none free";
        clear_ctx();
        for (int t = 0; t < N; t++) set_ctx(t, 2'd1, 1, 0, 1);
        do_fork(32'h0000_5000, 5'd4, 32'h7777_8888, 2'd1, 8'h10);

        // R7: single-context pool, wrong VPE
        scen = "R7 single ctx";
        clear_ctx();
        set_ctx(0, 2'd3, 1, 0, 0);
        ctx_limit = 3'd0;
        do_fork(32'h0000_5100, 5'd5, 32'h9999_AAAA, 2'd0, 8'h20);

        // R9: request held high with new operands during the search
        scen = "R9 busy ignore";
        clear_ctx();
        set_ctx(6, 2'd1, 1, 0, 0);
        ctx_limit = 3'd7;
        @(negedge clk);
        fork_pc = 32'h0000_6000; fork_rd = 5'd11; fork_val = 32'hABCD_0001;
        req_mode = 2'd2; req_asid = 8'h66; fork_req = 1'b1;
        @(negedge clk);
        fork_pc = 32'hFFFF_0000; fork_rd = 5'd12; fork_val = 32'h0000_FFFF;
        req_mode = 2'd3; req_asid = 8'h99;
        repeat (4) @(negedge clk);
        fork_req = 1'b0;
        wait_idle();

        // R10 / R9: request held across CLAIM, accepted only from IDLE
        scen = "R10 back to back";
        clear_ctx();
        set_ctx(1, 2'd1, 1, 0, 0);
        @(negedge clk);
        fork_pc = 32'h0000_7000; fork_rd = 5'd13; fork_val = 32'h2468_ACE0;
        req_mode = 2'd1; req_asid = 8'h3C; fork_req = 1'b1;
        repeat (6) @(negedge clk);
        fork_req = 1'b0;
        wait_idle();

        // R6: other VPE, distinct mode and ASID
        scen = "R6 inherit";
        clear_ctx();
        req_vpe = 2'd3;
        set_ctx(0, 2'd1, 1, 0, 0);
        set_ctx(2, 2'd3, 1, 0, 0);
        do_fork(32'h0000_8000, 5'd0, 32'h0F0F_0F0F, 2'd3, 8'hC5);

        // R11: reset mid-search clears everything
        scen = "R11 reset mid";
        clear_ctx();
        set_ctx(7, 2'd3, 1, 0, 0);
        @(negedge clk);
        fork_req = 1'b1;
        @(negedge clk);
        fork_req = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog R8 (%s): actual hung expected done", scen);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule